// File: doc/BRIEF.md
# I2C Target Write Receiver with Tagged Event Queue

This block is the receive side of an I2C target. It watches already-filtered, already-sampled SCL and SDA levels. It recognises START, repeated START and STOP conditions and shifts in bytes on SCL rising edges. It decodes up to two own addresses, each in 7-bit or 10-bit form, and can optionally answer the general-call address. When a write is addressed to it, the block drives the acknowledge bit according to per-target enables. Address recognition and data acknowledgement are set separately.

Every data byte received in an addressed write goes into a small queue as one entry, together with a flag word. The flags say which target the byte belongs to, whether it was acknowledged, and whether it was the first byte after the address. A STOP or repeated START that closes an addressed write takes an entry of its own, and software discards that entry by popping it once. Software may read the head entry's flags and data without popping. A service output stays high while the queue holds anything, and a one-cycle pulse marks the end of a write transfer.

Top module: `i2c_tgt_rxq`

## Requirements
- R1: After reset the queue is empty, SDA is released, and the head data and head flags read zero. START is SDA falling while SCL stays high, STOP is SDA rising while SCL stays high, and data bits are sampled on SCL rising edges, most significant bit first.
- R2: The acknowledge is given by pulling SDA low during the ninth SCL clock. The pull is applied and removed only while SCL is low.
- R3: A first byte whose upper seven bits equal an own address, with the R/W bit (bit 0) clear, is acknowledged. The address must be enabled (decode control bit 2 for address 1, bit 4 for address 2) and its 10-bit mode bit must be clear (bit 3 and bit 5 respectively). Address 1 wins over address 2. Any other first byte is not acknowledged.
- R4: In 10-bit mode, a first byte of 11110, address bits 9:8 and a 0 is acknowledged. The following byte is acknowledged only if it equals address bits 7:0 of the same address.
- R5: A first byte of 0x00 is a general call. It is acknowledged when the own-master input is high and decode control bit 0 is set, or when the own-master input is low and decode control bit 1 is set.
- R6: A data byte is acknowledged when its target's receive control bit is set: bit 0 for address 1, bit 1 for address 2, bit 2 for general call. A byte that is not acknowledged for this reason is still stored.
- R7: Data entry flags use these bit positions: bit 0 is set for address 1, bit 1 for address 2, and both bits are set for general call. Bit 2 means the byte was acknowledged. Bit 3 (timeout NAK) always reads 0. Bit 4 marks the first data byte after the address phase.
- R8: When the queue is full, an incoming data byte is not acknowledged and not stored. A STOP or repeated-START entry that finds the queue full is dropped.
- R9: The service output is high exactly while the queue holds at least one entry. The head flags and head data can be read without popping and read zero when the queue is empty.
- R10: A one-cycle pop pulse removes the head entry. A pop on an empty queue has no effect.
- R11: A STOP that ends an addressed write stores an entry with flag bit 6 set and data 0. The write-done output then pulses for one cycle.
- R12: A repeated START during an addressed write stores an entry with flag bit 5 set and data 0, and a new address phase follows.
- R13: A transfer that is not addressed to the block, including any read request, stores nothing and produces no write-done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL level |
| sda_i | input | 1 | Sampled SDA level |
| sda_pull_o | output | 1 | Pull SDA low (acknowledge) |
| dec_ctl_i | input | 6 | Address decode control: bit 0 own-master general call, bit 1 external general call, bit 2 addr 1 enable, bit 3 addr 1 10-bit, bit 4 addr 2 enable, bit 5 addr 2 10-bit |
| ack_ctl_i | input | 3 | Data acknowledge enables: bit 0 addr 1, bit 1 addr 2, bit 2 general call |
| own_a1_i | input | 10 | Own address 1 |
| own_a2_i | input | 10 | Own address 2 |
| self_gc_i | input | 1 | High when the general call on the bus comes from this chip's own host |
| pop_i | input | 1 | Pop the head entry (data register read) |
| head_data_o | output | 8 | Data byte of the head entry |
| head_flags_o | output | 7 | Flag word of the head entry |
| svc_o | output | 1 | Queue needs service (non-empty) |
| wr_done_o | output | 1 | One-cycle pulse at the end of an addressed write |

## Verification
The hardest situation to reach is a data byte arriving while the queue is full, followed by a closing STOP that also finds no room. Popping normally keeps pace with the bus. The stimulus reaches this case by sending more bytes in one addressed write than the queue depth, without popping in between. It then checks that the extra byte was refused on the bus, and drains the queue to confirm that neither the extra byte nor the STOP entry was stored. The 10-bit two-byte handshake and the general-call split between own-master and external senders are also reached only through multi-byte bus sequences, so each gets its own directed frame.

// File: rtl/i2c_tgt_rxq_pkg.sv
package i2c_tgt_rxq_pkg;

  localparam int ADDR_W = 10;
  localparam int FLAG_W = 7;

  localparam int F_HIT1   = 0;
  localparam int F_HIT2   = 1;
  localparam int F_ACKD   = 2;
  localparam int F_TONAK  = 3;
  localparam int F_FIRST  = 4;
  localparam int F_RSTART = 5;
  localparam int F_STOP   = 6;

  typedef struct packed {
    logic [FLAG_W-1:0] flags;
    logic [7:0]        data;
  } entry_t;

  typedef enum logic [1:0] {TGT_NONE, TGT_A1, TGT_A2, TGT_GC} tgt_e;

  typedef enum logic [2:0] {PH_IDLE, PH_ADDR, PH_ADDR_LO, PH_DATA, PH_SKIP} phase_e;

  // 7-bit write address hit
  function automatic logic hit7(input logic [7:0] b, input logic en, input logic ten,
                                input logic [ADDR_W-1:0] a);
    return en && !ten && !b[0] && (b[7:1] == a[6:0]);
  endfunction

  // 10-bit header (write) hit
  function automatic logic hit10_hdr(input logic [7:0] b, input logic en, input logic ten,
                                     input logic [ADDR_W-1:0] a);
    return en && ten && (b[7:3] == 5'b11110) && (b[2:1] == a[9:8]) && !b[0];
  endfunction

endpackage

// File: rtl/i2c_tgt_rxq_cond.sv
module i2c_tgt_rxq_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign scl_rise_o = scl_i && !scl_q;
  assign scl_fall_o = !scl_i && scl_q;
  assign start_o    = scl_i && scl_q && sda_q && !sda_i;
  assign stop_o     = scl_i && scl_q && !sda_q && sda_i;
endmodule

// File: rtl/i2c_tgt_rxq_dec.sv
module i2c_tgt_rxq_dec
  import i2c_tgt_rxq_pkg::*;
(
  input  logic [7:0]        byte_i,
  input  logic [5:0]        dec_i,
  input  logic [ADDR_W-1:0] a1_i,
  input  logic [ADDR_W-1:0] a2_i,
  input  logic              self_gc_i,
  input  logic [1:0]        cand_i,
  output tgt_e              tgt7_o,
  output logic [1:0]        cand_o,
  output tgt_e              tgt10_o
);
  logic gc_ok;

  assign gc_ok = (byte_i == 8'h00) && (self_gc_i ? dec_i[0] : dec_i[1]);

  assign cand_o[0] = hit10_hdr(byte_i, dec_i[2], dec_i[3], a1_i);
  assign cand_o[1] = hit10_hdr(byte_i, dec_i[4], dec_i[5], a2_i);

  always_comb begin
    if (gc_ok)                                   tgt7_o = TGT_GC;
    else if (hit7(byte_i, dec_i[2], dec_i[3], a1_i)) tgt7_o = TGT_A1;
    else if (hit7(byte_i, dec_i[4], dec_i[5], a2_i)) tgt7_o = TGT_A2;
    else                                         tgt7_o = TGT_NONE;
  end

  always_comb begin
    if (cand_i[0] && (byte_i == a1_i[7:0]))      tgt10_o = TGT_A1;
    else if (cand_i[1] && (byte_i == a2_i[7:0])) tgt10_o = TGT_A2;
    else                                         tgt10_o = TGT_NONE;
  end
endmodule

// File: rtl/i2c_tgt_rxq_fifo.sv
module i2c_tgt_rxq_fifo #(
  parameter int DEPTH = 4,
  parameter int W     = 15,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] dout_o,
  output logic         full_o,
  output logic         empty_o,
  output logic [LW-1:0] lvl_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [LW-1:0] cnt;
  logic          do_push, do_pop;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt == LW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign dout_o  = mem[rp];
  assign lvl_o   = cnt;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/i2c_tgt_rxq.sv
module i2c_tgt_rxq
  import i2c_tgt_rxq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  input  logic [5:0]        dec_ctl_i,
  input  logic [2:0]        ack_ctl_i,
  input  logic [ADDR_W-1:0] own_a1_i,
  input  logic [ADDR_W-1:0] own_a2_i,
  input  logic              self_gc_i,
  input  logic              pop_i,
  output logic [7:0]        head_data_o,
  output logic [FLAG_W-1:0] head_flags_o,
  output logic              svc_o,
  output logic              wr_done_o
);
  // bus events
  logic scl_rise, scl_fall, start_ev, stop_ev;

  i2c_tgt_rxq_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall), .start_o(start_ev), .stop_o(stop_ev)
  );

  // protocol state
  phase_e     phase_q, ph_nxt;
  tgt_e       tgt_q, tgt_nxt;
  logic [1:0] cand_q;
  logic [3:0] bit_q;
  logic [7:0] sh_q;
  logic       in_ack_q, pull_q, active_q, first_q, done_q;

  // decode
  tgt_e       tgt7, tgt10;
  logic [1:0] cand;

  i2c_tgt_rxq_dec u_dec (
    .byte_i(sh_q), .dec_i(dec_ctl_i), .a1_i(own_a1_i), .a2_i(own_a2_i),
    .self_gc_i(self_gc_i), .cand_i(cand_q),
    .tgt7_o(tgt7), .cand_o(cand), .tgt10_o(tgt10)
  );

  // queue
  logic             push_req, fifo_full, fifo_empty;
  logic [LVL_W-1:0] fifo_lvl;
  entry_t           push_ent, head;

  i2c_tgt_rxq_fifo #(.DEPTH(DEPTH), .W($bits(entry_t))) u_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(push_req), .din_i(push_ent), .pop_i(pop_i),
    .dout_o(head), .full_o(fifo_full), .empty_o(fifo_empty), .lvl_o(fifo_lvl)
  );

  // named internal events
  logic byte_done, counting, in_data, data_ack_en, ack_now, adr_hit;

  assign counting  = (phase_q == PH_ADDR) || (phase_q == PH_ADDR_LO) || (phase_q == PH_DATA);
  assign byte_done = scl_fall && !in_ack_q && (bit_q == 4'd8) && counting;
  assign in_data   = (phase_q == PH_DATA);

  always_comb begin
    case (tgt_q)
      TGT_A1:  data_ack_en = ack_ctl_i[0];
      TGT_A2:  data_ack_en = ack_ctl_i[1];
      TGT_GC:  data_ack_en = ack_ctl_i[2];
      default: data_ack_en = 1'b0;
    endcase
  end

  always_comb begin
    ack_now  = 1'b0;
    push_req = 1'b0;
    push_ent = '0;
    ph_nxt   = phase_q;
    tgt_nxt  = tgt_q;
    adr_hit  = 1'b0;
    if (start_ev || stop_ev) begin
      if (active_q && !fifo_full) begin
        push_req = 1'b1;
        if (start_ev) push_ent.flags[F_RSTART] = 1'b1;
        else          push_ent.flags[F_STOP]   = 1'b1;
      end
    end else if (byte_done) begin
      case (phase_q)
        PH_ADDR: begin
          if (cand != 2'b00) begin
            ack_now = 1'b1;
            ph_nxt  = PH_ADDR_LO;
          end else if (tgt7 != TGT_NONE) begin
            ack_now = 1'b1;
            ph_nxt  = PH_DATA;
            tgt_nxt = tgt7;
            adr_hit = 1'b1;
          end else begin
            ph_nxt  = PH_SKIP;
          end
        end
        PH_ADDR_LO: begin
          if (tgt10 != TGT_NONE) begin
            ack_now = 1'b1;
            ph_nxt  = PH_DATA;
            tgt_nxt = tgt10;
            adr_hit = 1'b1;
          end else begin
            ph_nxt  = PH_SKIP;
          end
        end
        PH_DATA: begin
          if (!fifo_full) begin
            ack_now                 = data_ack_en;
            push_req                = 1'b1;
            push_ent.data           = sh_q;
            push_ent.flags[F_HIT1]  = (tgt_q == TGT_A1) || (tgt_q == TGT_GC);
            push_ent.flags[F_HIT2]  = (tgt_q == TGT_A2) || (tgt_q == TGT_GC);
            push_ent.flags[F_ACKD]  = data_ack_en;
            push_ent.flags[F_FIRST] = first_q;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q  <= PH_IDLE;
      tgt_q    <= TGT_NONE;
      cand_q   <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
      in_ack_q <= 1'b0;
      pull_q   <= 1'b0;
      active_q <= 1'b0;
      first_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= stop_ev && active_q;
      if (start_ev || stop_ev) begin
        phase_q  <= start_ev ? PH_ADDR : PH_IDLE;
        tgt_q    <= TGT_NONE;
        cand_q   <= '0;
        bit_q    <= '0;
        in_ack_q <= 1'b0;
        pull_q   <= 1'b0;
        active_q <= 1'b0;
        first_q  <= 1'b0;
      end else if (byte_done) begin
        in_ack_q <= 1'b1;
        pull_q   <= ack_now;
        phase_q  <= ph_nxt;
        tgt_q    <= tgt_nxt;
        if (phase_q == PH_ADDR) cand_q <= cand;
        if (adr_hit) begin
          active_q <= 1'b1;
          first_q  <= 1'b1;
        end else if (in_data) begin
          first_q  <= 1'b0;
        end
      end else if (scl_fall && in_ack_q) begin
        in_ack_q <= 1'b0;
        pull_q   <= 1'b0;
        bit_q    <= '0;
      end else if (scl_rise && !in_ack_q && counting && (bit_q < 4'd8)) begin
        sh_q  <= {sh_q[6:0], sda_i};
        bit_q <= bit_q + 1'b1;
      end
    end
  end

  assign sda_pull_o   = pull_q;
  assign wr_done_o    = done_q;
  assign svc_o        = !fifo_empty;
  assign head_data_o  = fifo_empty ? '0 : head.data;
  assign head_flags_o = fifo_empty ? '0 : head.flags;
endmodule

// File: rtl/i2c_tgt_rxq_chk.sv
module i2c_tgt_rxq_chk #(
  parameter int LVL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_i,
  input logic             sda_pull_o,
  input logic             svc_o,
  input logic             wr_done_o,
  input logic             pop_i,
  input logic             stop_ev,
  input logic             byte_done,
  input logic             in_data,
  input logic             fifo_full,
  input logic             push_req,
  input logic [LVL_W-1:0] fifo_lvl
);
  // R2: acknowledge pull starts only while SCL is low
  a_r2_pull_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !$past(scl_i));

  // R8: a data byte arriving at a full queue is refused
  a_r8_full_nak: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && in_data && fifo_full) |=> !sda_pull_o);

  // R9: service rises only after an entry went in
  a_r9_svc_after_push: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(svc_o) |-> $past(push_req));

  // R10: popping the last entry clears service
  a_r10_pop_last: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && (fifo_lvl == LVL_W'(1)) && !push_req) |=> !svc_o);

  // R11: write-done follows a STOP
  a_r11_done_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done_o |-> $past(stop_ev));
endmodule

bind i2c_tgt_rxq i2c_tgt_rxq_chk #(.LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_pull_o(sda_pull_o), .svc_o(svc_o),
  .wr_done_o(wr_done_o), .pop_i(pop_i), .stop_ev(stop_ev), .byte_done(byte_done),
  .in_data(in_data), .fifo_full(fifo_full), .push_req(push_req), .fifo_lvl(fifo_lvl)
);

// File: tb/i2c_tgt_rxq_bench.sv
module i2c_tgt_rxq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 4;
  localparam int NVEC = 5;

  // {addr7[22:16], data[15:8], ack[7], flags[6:0]}
  localparam logic [22:0] VEC [NVEC] = '{
    {7'h2A, 8'h5C, 1'b1, 7'h15},
    {7'h51, 8'hA3, 1'b1, 7'h16},
    {7'h33, 8'h99, 1'b0, 7'h00},
    {7'h2A, 8'h00, 1'b1, 7'h15},
    {7'h51, 8'hFF, 1'b1, 7'h16}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_pull;
  logic sda_line;
  logic [5:0] dec = 6'h14;
  logic [2:0] ackc = 3'b011;
  logic [9:0] a1 = 10'h02A;
  logic [9:0] a2 = 10'h051;
  logic self_gc = 1'b0;
  logic pop = 1'b0;
  logic [7:0] hd;
  logic [6:0] hf;
  logic svc, wr_done;
  int total = 0;
  int bad = 0;
  int done_n = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  i2c_tgt_rxq u_i2c_tgt_rxq (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_pull_o(sda_pull),
    .dec_ctl_i(dec), .ack_ctl_i(ackc), .own_a1_i(a1), .own_a2_i(a2), .self_gc_i(self_gc),
    .pop_i(pop), .head_data_o(hd), .head_flags_o(hf), .svc_o(svc), .wr_done_o(wr_done)
  );

  always @(posedge clk) if (rst_n && wr_done) done_n++;

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_start();
    sda_m = 1'b1; scl = 1'b1; hold(Q);
    sda_m = 1'b0; hold(Q);
    scl = 1'b0; hold(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1'b1; hold(Q);
    scl = 1'b1; hold(Q);
    sda_m = 1'b0; hold(Q);
    scl = 1'b0; hold(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; hold(Q);
    scl = 1'b1; hold(Q);
    sda_m = 1'b1; hold(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; hold(Q);
      scl = 1'b1; hold(2*Q);
      scl = 1'b0; hold(Q);
    end
    sda_m = 1'b1; hold(Q);
    scl = 1'b1; hold(Q);
    ack = !sda_line;
    hold(Q);
    scl = 1'b0; hold(Q);
  endtask

  task automatic take(input string tag, input logic [6:0] ef, input logic [7:0] ed);
    check({tag, " flags"}, 32'(hf), 32'(ef));
    check({tag, " data"}, 32'(hd), 32'(ed));
    pop = 1'b1; hold(1);
    pop = 1'b0; hold(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic ack;
    logic [22:0] v;
    int d0;
    hold(5);
    rst_n = 1'b1;
    hold(3);
    // R1 / R9: reset state
    check("R1 reset svc", 32'(svc), 0);
    check("R1 reset pull", 32'(sda_pull), 0);
    check("R9 reset flags", 32'(hf), 0);
    check("R9 reset data", 32'(hd), 0);

    // table walk: R3 R7 R11 R13
    for (int i = 0; i < NVEC; i++) begin
      v = VEC[i];
      d0 = done_n;
      bus_start();
      send_byte({v[22:16], 1'b0}, ack);
      check("R3 addr ack", 32'(ack), 32'(v[7]));
      if (v[7]) begin
        send_byte(v[15:8], ack);
        check("R6 data ack", 32'(ack), 1);
      end
      bus_stop(); hold(2);
      if (v[7]) begin
        take("R7 vec entry", v[6:0], v[15:8]);
        take("R11 stop entry", 7'h40, 8'h00);
        check("R11 done pulse", 32'(done_n - d0), 1);
      end else begin
        check("R13 no done", 32'(done_n - d0), 0);
      end
      check("R9 drained", 32'(svc), 0);
    end

    // R7 R9: multi-byte, first flag, peek without pop
    bus_start();
    send_byte(8'h54, ack);
    send_byte(8'h11, ack);
    send_byte(8'h22, ack);
    bus_stop(); hold(2);
    check("R9 svc set", 32'(svc), 1);
    check("R9 peek 1", 32'(hf), 32'h15);
    hold(6);
    check("R9 peek 2", 32'(hf), 32'h15);
    take("R7 first", 7'h15, 8'h11);
    take("R7 second", 7'h05, 8'h22);
    take("R11 stop", 7'h40, 8'h00);

    // R12: repeated START
    bus_start();
    send_byte(8'h54, ack);
    send_byte(8'hA1, ack);
    bus_rstart();
    send_byte(8'hA2, ack);
    check("R12 readdress ack", 32'(ack), 1);
    send_byte(8'hB2, ack);
    bus_stop(); hold(2);
    take("R12 pre", 7'h15, 8'hA1);
    take("R12 rs entry", 7'h20, 8'h00);
    take("R12 post", 7'h16, 8'hB2);
    take("R12 stop", 7'h40, 8'h00);

    // R4: 10-bit addressing
    dec = 6'h1C; a1 = 10'h2A5;
    bus_start();
    send_byte(8'hF4, ack); check("R4 hdr ack", 32'(ack), 1);
    send_byte(8'hA5, ack); check("R4 low ack", 32'(ack), 1);
    send_byte(8'h3C, ack); check("R4 data ack", 32'(ack), 1);
    bus_stop(); hold(2);
    take("R4 entry", 7'h15, 8'h3C);
    take("R4 stop", 7'h40, 8'h00);
    bus_start();
    send_byte(8'hF4, ack);
    send_byte(8'hA4, ack); check("R4 wrong low nak", 32'(ack), 0);
    bus_stop(); hold(2);
    check("R4 nothing stored", 32'(svc), 0);
    bus_start();
    send_byte(8'h4A, ack); check("R3 ten-bit not 7-bit", 32'(ack), 0);
    bus_stop(); hold(2);
    dec = 6'h14; a1 = 10'h02A;

    // R5: general call
    dec = 6'h16; ackc = 3'b111; self_gc = 1'b0;
    bus_start();
    send_byte(8'h00, ack); check("R5 ext gc ack", 32'(ack), 1);
    send_byte(8'h77, ack);
    bus_stop(); hold(2);
    take("R5 gc entry", 7'h17, 8'h77);
    take("R5 gc stop", 7'h40, 8'h00);
    self_gc = 1'b1;
    bus_start();
    send_byte(8'h00, ack); check("R5 own gc off nak", 32'(ack), 0);
    bus_stop(); hold(2);
    dec = 6'h15;
    bus_start();
    send_byte(8'h00, ack); check("R5 own gc on ack", 32'(ack), 1);
    send_byte(8'h78, ack);
    bus_stop(); hold(2);
    take("R5 own gc entry", 7'h17, 8'h78);
    take("R5 own gc stop", 7'h40, 8'h00);
    dec = 6'h14; ackc = 3'b011; self_gc = 1'b0;

    // R6: data ack disabled, byte still stored
    ackc = 3'b010;
    bus_start();
    send_byte(8'h54, ack); check("R6 addr ack", 32'(ack), 1);
    send_byte(8'h99, ack); check("R6 data nak", 32'(ack), 0);
    bus_stop(); hold(2);
    take("R6 entry", 7'h11, 8'h99);
    take("R6 stop", 7'h40, 8'h00);
    ackc = 3'b011;

    // R13: read request ignored
    d0 = done_n;
    bus_start();
    send_byte(8'h55, ack); check("R13 read nak", 32'(ack), 0);
    bus_stop(); hold(2);
    check("R13 read none", 32'(svc), 0);
    check("R13 read no done", 32'(done_n - d0), 0);

    // R8: overflow
    d0 = done_n;
    bus_start();
    send_byte(8'h54, ack);
    for (int k = 1; k <= 4; k++) begin
      send_byte(8'(k), ack);
      check("R8 fill ack", 32'(ack), 1);
    end
    send_byte(8'h05, ack); check("R8 full nak", 32'(ack), 0);
    bus_stop(); hold(2);
    check("R11 done when full", 32'(done_n - d0), 1);
    take("R8 e1", 7'h15, 8'h01);
    take("R8 e2", 7'h05, 8'h02);
    take("R8 e3", 7'h05, 8'h03);
    take("R8 e4", 7'h05, 8'h04);
    check("R8 no extra", 32'(svc), 0);

    // R10: pop on empty
    pop = 1'b1; hold(1); pop = 1'b0; hold(1);
    check("R10 empty pop svc", 32'(svc), 0);
    check("R10 empty pop flags", 32'(hf), 0);
    bus_start();
    send_byte(8'h54, ack);
    send_byte(8'h66, ack);
    bus_stop(); hold(2);
    take("R10 after", 7'h15, 8'h66);
    take("R10 stop", 7'h40, 8'h00);
    check("R10 final empty", 32'(svc), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule